// File: doc/BRIEF.md
# Systolic Local-Alignment Scoring Array

This block fills the local-alignment score matrix for two symbol strings using a chain of processing elements. Each element is bound to one query symbol and owns one matrix column. The database string enters the first element one symbol per clock while an enable line is high. Symbol and enable then step one element per clock down the chain, so every element fills its column one row behind its left neighbour. Cell scores use a linear gap cost and a fixed match/mismatch value, and are never below zero.

For every cell, an element emits a 2-bit pointer code and a row address, meant for an external pointer store that a later traceback pass reads. The best score seen so far, with its row and column, travels down the chain beside the data. The last element therefore presents the global maximum of the matrix and where it first occurred. A ready flag tells the traceback side that scoring has finished and that the maximum outputs are final.

Top module: `sw_score_array`

## Requirements
- R1: Cell (i,j) scores the maximum of 0, H(i-1,j-1)+s, H(i-1,j)-GAP and H(i,j-1)-GAP, where s is MATCH when the database symbol equals query symbol j and MISMATCH otherwise; row 0 and column 0 count as zero.
- R2: The pointer code is 2 (diagonal) when the diagonal candidate is at least as large as both gap candidates. Otherwise it is 1 (up) when the up candidate is strictly larger than the left one, else 3 (left).
- R3: When a cell's best candidate is zero or negative, its score is 0 and its pointer code is 0.
- R4: Element j (0-based) samples the database symbol and enable j clock edges after the first element. Its first write strobe appears j+1 edges after the first enable is sampled at the block input.
- R5: Each element raises its write strobe exactly once per database symbol. The write address is the 0-based row, i-1, carried in bits [j*ROW_W +: ROW_W] of the address bus. The code is carried in bits [2j +: 2] of the code bus.
- R6: The maximum outputs report the largest score of the whole matrix, with its 1-based row and column. On ties, the position first in row-major order wins. An all-zero matrix reports 0 at row 0, column 0.
- R7: The score width is derived from N and MATCH so that a full-length match of N symbols reports N*MATCH without wrapping.
- R8: The ready flag drops on the first enabled input cycle of a run. It rises N edges after the last enable is sampled, with the maximum outputs unchanged on that edge. It then stays high until the next run.
- R9: Synchronous active-high reset clears the ready flag, the maximum outputs and all write strobes.
- R10: A run that starts at least one idle cycle after the previous run computes its matrix and maximum without influence from earlier runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_in | input | 1 | High for each database symbol of a run |
| sym_in | input | SYM_W (3) | Database symbol |
| query | input | N*SYM_W | Query symbols, element j at [j*SYM_W +: SYM_W]; held stable during a run |
| dir_we | output | N | Per-element pointer write strobe |
| dir_code | output | 2*N | Per-element pointer code |
| dir_addr | output | N*ROW_W | Per-element pointer row address |
| max_score | output | SCORE_W | Best score of the matrix |
| max_row | output | ROW_W | 1-based row of the best score |
| max_col | output | COL_W | 1-based column of the best score |
| tb_ready | output | 1 | Scoring finished, traceback may start |

## Verification
The bench builds the array with eight elements, 8-bit row addresses and the default scores of +5, -5 and gap 1. With only eight columns, the bench can compare every pointer code and address of every run against a full matrix computed in software. Database runs from one symbol up to sixty rows exercise runs both shorter and longer than the chain. The four-letter random alphabet makes score ties, tied gap candidates and zero clamps frequent. An all-mismatch run placed right after a perfect-match run exposes any maximum carried over between runs.

// File: rtl/sw_pkg.sv
package sw_pkg;

    localparam int SYM_W = 3;

    typedef enum logic [1:0] {
        DIR_STOP = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DIAG = 2'd2,
        DIR_LEFT = 2'd3
    } dir_e;

    typedef struct packed {
        logic signed [31:0] score;
        dir_e               dir;
    } cell_res_t;

    // Substitution value for a pair of symbols
    function automatic int subst(input logic [SYM_W-1:0] a,
                                 input logic [SYM_W-1:0] b,
                                 input int m, input int mm);
        return (a == b) ? m : mm;
    endfunction

    // Choose among the three candidates; diagonal wins ties, left wins up/left ties
    function automatic cell_res_t cell_pick(input int diag_c, input int up_c,
                                            input int left_c);
        cell_res_t r;
        if (diag_c >= up_c && diag_c >= left_c) begin
            r.score = diag_c;
            r.dir   = DIR_DIAG;
        end else if (up_c > left_c) begin
            r.score = up_c;
            r.dir   = DIR_UP;
        end else begin
            r.score = left_c;
            r.dir   = DIR_LEFT;
        end
        if (r.score <= 0) begin
            r.score = 0;
            r.dir   = DIR_STOP;
        end
        return r;
    endfunction

endpackage

// File: rtl/sw_cell_core.sv
module sw_cell_core
    import sw_pkg::*;
#(
    parameter int SCORE_W  = 6,
    parameter int MATCH    = 5,
    parameter int MISMATCH = -5,
    parameter int GAP      = 1
) (
    input  logic [SYM_W-1:0]   q_sym,
    input  logic [SYM_W-1:0]   s_sym,
    input  logic [SCORE_W-1:0] diag_score,
    input  logic [SCORE_W-1:0] up_score,
    input  logic [SCORE_W-1:0] left_score,
    output logic [SCORE_W-1:0] cell_score,
    output dir_e               cell_dir
);
    cell_res_t res;
    int        diag_c;
    int        up_c;
    int        left_c;

    always_comb begin
        diag_c     = int'(diag_score) + subst(q_sym, s_sym, MATCH, MISMATCH);
        up_c       = int'(up_score) - GAP;
        left_c     = int'(left_score) - GAP;
        res        = cell_pick(diag_c, up_c, left_c);
        cell_score = res.score[SCORE_W-1:0];
        cell_dir   = res.dir;
    end
endmodule

// File: rtl/sw_max_merge.sv
module sw_max_merge #(
    parameter int SCORE_W = 6,
    parameter int ROW_W   = 8,
    parameter int COL_W   = 4
) (
    input  logic [SCORE_W-1:0] a_score,
    input  logic [ROW_W-1:0]   a_row,
    input  logic [COL_W-1:0]   a_col,
    input  logic [SCORE_W-1:0] b_score,
    input  logic [ROW_W-1:0]   b_row,
    input  logic [COL_W-1:0]   b_col,
    output logic [SCORE_W-1:0] o_score,
    output logic [ROW_W-1:0]   o_row,
    output logic [COL_W-1:0]   o_col
);
    logic a_wins;

    // Higher score wins; equal scores go to the earlier row-major position
    always_comb begin
        a_wins = (a_score > b_score) ||
                 ((a_score == b_score) && ({a_row, a_col} < {b_row, b_col}));
        o_score = a_wins ? a_score : b_score;
        o_row   = a_wins ? a_row   : b_row;
        o_col   = a_wins ? a_col   : b_col;
    end
endmodule

// File: rtl/sw_pe.sv
module sw_pe
    import sw_pkg::*;
#(
    parameter int SCORE_W  = 6,
    parameter int ROW_W    = 8,
    parameter int COL_W    = 4,
    parameter int MATCH    = 5,
    parameter int MISMATCH = -5,
    parameter int GAP      = 1,
    parameter int COL_IDX  = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SYM_W-1:0]   q_sym,
    input  logic               en_in,
    input  logic [SYM_W-1:0]   s_in,
    input  logic [SCORE_W-1:0] left_score,
    input  logic [SCORE_W-1:0] mx_in_score,
    input  logic [ROW_W-1:0]   mx_in_row,
    input  logic [COL_W-1:0]   mx_in_col,
    output logic               en_q,
    output logic [SYM_W-1:0]   s_q,
    output logic [SCORE_W-1:0] score_q,
    output logic [SCORE_W-1:0] mx_score_q,
    output logic [ROW_W-1:0]   mx_row_q,
    output logic [COL_W-1:0]   mx_col_q,
    output logic               dir_we_q,
    output logic [1:0]         dir_q,
    output logic [ROW_W-1:0]   waddr_q
);
    localparam logic [COL_W-1:0] MY_COL = COL_W'(COL_IDX);

    logic [ROW_W-1:0]   row_q;
    logic [SCORE_W-1:0] diag_q;
    logic [SCORE_W-1:0] cell_score;
    dir_e               cell_dir;
    logic               new_run;
    logic [SCORE_W-1:0] self_score;
    logic [ROW_W-1:0]   self_row;
    logic [COL_W-1:0]   self_col;
    logic [SCORE_W-1:0] m1_score, m2_score;
    logic [ROW_W-1:0]   m1_row,   m2_row;
    logic [COL_W-1:0]   m1_col,   m2_col;
    logic [ROW_W-1:0]   cell_row;

    sw_cell_core #(
        .SCORE_W(SCORE_W), .MATCH(MATCH), .MISMATCH(MISMATCH), .GAP(GAP)
    ) u_core (
        .q_sym(q_sym), .s_sym(s_in), .diag_score(diag_q), .up_score(score_q),
        .left_score(left_score), .cell_score(cell_score), .cell_dir(cell_dir)
    );

    // The carried maximum of this element is forgotten at the first row of a run
    always_comb begin
        new_run    = (row_q == '0);
        self_score = new_run ? '0 : mx_score_q;
        self_row   = new_run ? '0 : mx_row_q;
        self_col   = new_run ? '0 : mx_col_q;
        cell_row   = row_q + 1'b1;
    end

    sw_max_merge #(.SCORE_W(SCORE_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_merge_prev (
        .a_score(self_score), .a_row(self_row), .a_col(self_col),
        .b_score(mx_in_score), .b_row(mx_in_row), .b_col(mx_in_col),
        .o_score(m1_score), .o_row(m1_row), .o_col(m1_col)
    );

    sw_max_merge #(.SCORE_W(SCORE_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_merge_cell (
        .a_score(m1_score), .a_row(m1_row), .a_col(m1_col),
        .b_score(cell_score), .b_row(cell_row), .b_col(MY_COL),
        .o_score(m2_score), .o_row(m2_row), .o_col(m2_col)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            s_q        <= '0;
            score_q    <= '0;
            diag_q     <= '0;
            row_q      <= '0;
            mx_score_q <= '0;
            mx_row_q   <= '0;
            mx_col_q   <= '0;
            dir_we_q   <= 1'b0;
            dir_q      <= DIR_STOP;
            waddr_q    <= '0;
        end else begin
            en_q     <= en_in;
            s_q      <= s_in;
            dir_we_q <= en_in;
            if (en_in) begin
                score_q    <= cell_score;
                diag_q     <= left_score;
                row_q      <= cell_row;
                mx_score_q <= m2_score;
                mx_row_q   <= m2_row;
                mx_col_q   <= m2_col;
                dir_q      <= cell_dir;
                waddr_q    <= row_q;
            end else begin
                score_q <= '0;
                diag_q  <= '0;
                row_q   <= '0;
            end
        end
    end

    // R3: stop code appears exactly on zero-score cells
    p_dir_stop_r3: assert property (@(posedge clk) disable iff (rst)
        dir_we_q |-> ((dir_q == DIR_STOP) == (score_q == '0)));

    // R4: enable moves one element per clock
    p_en_pipe_r4: assert property (@(posedge clk) disable iff (rst)
        en_q |-> $past(en_in));

    // R5: consecutive writes step the row address by one
    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (dir_we_q && $past(dir_we_q)) |-> (waddr_q == ROW_W'($past(waddr_q) + 1'b1)));

    // R6: within a run the carried maximum never falls
    p_max_mono_r6: assert property (@(posedge clk) disable iff (rst)
        (en_in && row_q != '0) |=> (mx_score_q >= $past(mx_score_q)));

    // R6: the carried maximum covers the cell just written
    p_max_cover_r6: assert property (@(posedge clk) disable iff (rst)
        dir_we_q |-> (mx_score_q >= score_q));
endmodule

// File: rtl/sw_score_array.sv
module sw_score_array
    import sw_pkg::*;
#(
    parameter int N        = 8,
    parameter int ROW_W    = 8,
    parameter int MATCH    = 5,
    parameter int MISMATCH = -5,
    parameter int GAP      = 1,
    localparam int SCORE_W = $clog2(N * MATCH + 1),
    localparam int COL_W   = $clog2(N + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_in,
    input  logic [SYM_W-1:0]     sym_in,
    input  logic [N*SYM_W-1:0]   query,
    output logic [N-1:0]         dir_we,
    output logic [2*N-1:0]       dir_code,
    output logic [N*ROW_W-1:0]   dir_addr,
    output logic [SCORE_W-1:0]   max_score,
    output logic [ROW_W-1:0]     max_row,
    output logic [COL_W-1:0]     max_col,
    output logic                 tb_ready
);
    logic               en_c  [0:N];
    logic [SYM_W-1:0]   s_c   [0:N];
    logic [SCORE_W-1:0] sc_c  [0:N];
    logic [SCORE_W-1:0] mxs_c [0:N];
    logic [ROW_W-1:0]   mxr_c [0:N];
    logic [COL_W-1:0]   mxc_c [0:N];
    logic               end_seen;

    assign en_c[0]  = en_in;
    assign s_c[0]   = sym_in;
    assign sc_c[0]  = '0;
    assign mxs_c[0] = '0;
    assign mxr_c[0] = '0;
    assign mxc_c[0] = '0;

    for (genvar j = 0; j < N; j++) begin : g_pe
        sw_pe #(
            .SCORE_W(SCORE_W), .ROW_W(ROW_W), .COL_W(COL_W),
            .MATCH(MATCH), .MISMATCH(MISMATCH), .GAP(GAP), .COL_IDX(j + 1)
        ) u_pe (
            .clk(clk), .rst(rst),
            .q_sym(query[j*SYM_W +: SYM_W]),
            .en_in(en_c[j]), .s_in(s_c[j]), .left_score(sc_c[j]),
            .mx_in_score(mxs_c[j]), .mx_in_row(mxr_c[j]), .mx_in_col(mxc_c[j]),
            .en_q(en_c[j+1]), .s_q(s_c[j+1]), .score_q(sc_c[j+1]),
            .mx_score_q(mxs_c[j+1]), .mx_row_q(mxr_c[j+1]), .mx_col_q(mxc_c[j+1]),
            .dir_we_q(dir_we[j]), .dir_q(dir_code[2*j +: 2]),
            .waddr_q(dir_addr[j*ROW_W +: ROW_W])
        );
    end

    assign max_score = mxs_c[N];
    assign max_row   = mxr_c[N];
    assign max_col   = mxc_c[N];

    // Last element wrote its final row on the previous edge
    assign end_seen = en_c[N] && !en_c[N-1];

    always_ff @(posedge clk) begin
        if (rst)           tb_ready <= 1'b0;
        else if (end_seen) tb_ready <= 1'b1;
        else if (en_in)    tb_ready <= 1'b0;
    end

    // R8: results are settled on the edge the flag rises
    p_ready_stable_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(tb_ready) |-> ($stable(max_score) && $stable(max_row) && $stable(max_col)));
endmodule

// File: tb/sw_score_array_bench.sv
`timescale 1ns/1ps
module sw_score_array_bench;
    import sw_pkg::*;

    localparam int N        = 8;
    localparam int ROW_W    = 8;
    localparam int MATCH    = 5;
    localparam int MISMATCH = -5;
    localparam int GAP      = 1;
    localparam int SCORE_W  = $clog2(N * MATCH + 1);
    localparam int COL_W    = $clog2(N + 1);
    localparam int MAXM     = 64;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 en_in;
    logic [SYM_W-1:0]     sym_in;
    logic [N*SYM_W-1:0]   query;
    logic [N-1:0]         dir_we;
    logic [2*N-1:0]       dir_code;
    logic [N*ROW_W-1:0]   dir_addr;
    logic [SCORE_W-1:0]   max_score;
    logic [ROW_W-1:0]     max_row;
    logic [COL_W-1:0]     max_col;
    logic                 tb_ready;

    sw_score_array #(.N(N), .ROW_W(ROW_W), .MATCH(MATCH), .MISMATCH(MISMATCH), .GAP(GAP))
    u_sw_score_array (
        .clk(clk), .rst(rst), .en_in(en_in), .sym_in(sym_in), .query(query),
        .dir_we(dir_we), .dir_code(dir_code), .dir_addr(dir_addr),
        .max_score(max_score), .max_row(max_row), .max_col(max_col), .tb_ready(tb_ready)
    );

    always #2.5 clk = ~clk;

    logic [SYM_W-1:0] qv [N];
    logic [SYM_W-1:0] sv [MAXM];
    int eh [0:MAXM][0:N];
    int ed [0:MAXM][0:N];
    int gd [0:MAXM-1][0:N-1];
    int first_we [N];
    int wr_cnt;
    int e_max, e_row, e_col;
    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    bit mon_on = 1'b0;

    always_comb begin
        for (int j = 0; j < N; j++) query[j*SYM_W +: SYM_W] = qv[j];
    end

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (mon_on) begin
            for (int j = 0; j < N; j++) begin
                if (dir_we[j]) begin
                    int a;
                    a = int'(dir_addr[j*ROW_W +: ROW_W]);
                    if (a < MAXM) gd[a][j] = int'(dir_code[2*j +: 2]);
                    wr_cnt++;
                    if (first_we[j] < 0) first_we[j] = cyc;
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference matrix, pointers and first row-major maximum
    task automatic compute_expected(input int m);
        for (int i = 0; i <= m; i++) begin
            eh[i][0] = 0;
            ed[i][0] = 0;
        end
        for (int j = 0; j <= N; j++) begin
            eh[0][j] = 0;
            ed[0][j] = 0;
        end
        e_max = 0; e_row = 0; e_col = 0;
        for (int i = 1; i <= m; i++) begin
            for (int j = 1; j <= N; j++) begin
                int dg, up, lf, best, d;
                dg = eh[i-1][j-1] + ((sv[i-1] == qv[j-1]) ? MATCH : MISMATCH);
                up = eh[i-1][j] - GAP;
                lf = eh[i][j-1] - GAP;
                if (dg >= up && dg >= lf) begin best = dg; d = 2; end
                else if (up > lf)        begin best = up; d = 1; end
                else                     begin best = lf; d = 3; end
                if (best <= 0) begin best = 0; d = 0; end
                eh[i][j] = best;
                ed[i][j] = d;
                if (best > e_max) begin e_max = best; e_row = i; e_col = j; end
            end
        end
    endtask

    // Entered and left at a falling edge
    task automatic run(input int m, input string name);
        int c0;
        for (int i = 0; i < MAXM; i++)
            for (int j = 0; j < N; j++) gd[i][j] = -1;
        for (int j = 0; j < N; j++) first_we[j] = -1;
        wr_cnt = 0;
        compute_expected(m);
        mon_on = 1'b1;
        c0 = cyc;
        for (int k = 0; k < m; k++) begin
            en_in  = 1'b1;
            sym_in = sv[k];
            @(negedge clk);
        end
        en_in = 1'b0;
        check({"R8 ready low after run start ", name}, int'(tb_ready), 0);
        repeat (N - 1) @(negedge clk);
        check({"R8 ready low one edge early ", name}, int'(tb_ready), 0);
        @(negedge clk);
        check({"R8 ready raised ", name}, int'(tb_ready), 1);
        check({"R1 R6 max score ", name}, int'(max_score), e_max);
        check({"R6 max row ", name}, int'(max_row), e_row);
        check({"R6 max col ", name}, int'(max_col), e_col);
        check({"R5 write count ", name}, wr_cnt, m * N);
        for (int j = 0; j < N; j++)
            check({"R4 first write cycle ", name}, first_we[j], c0 + j + 1);
        for (int i = 1; i <= m; i++) begin
            for (int j = 1; j <= N; j++) begin
                if (gd[i-1][j-1] < 0)
                    check({"R5 cell never written ", name}, gd[i-1][j-1], ed[i][j]);
                else if (ed[i][j] == 0)
                    check({"R3 stop code ", name}, gd[i-1][j-1], 0);
                else
                    check({"R2 pointer code ", name}, gd[i-1][j-1], ed[i][j]);
            end
        end
        repeat (4) @(negedge clk);
        check({"R8 ready held ", name}, int'(tb_ready), 1);
        mon_on = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; en_in = 1'b0; sym_in = '0;
        for (int j = 0; j < N; j++) qv[j] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R9 ready after reset", int'(tb_ready), 0);
        check("R9 max after reset", int'(max_score), 0);
        check("R9 strobes after reset", int'(dir_we), 0);
        @(negedge clk);

        // Perfect match over the full chain
        for (int j = 0; j < N; j++) qv[j] = SYM_W'(j);
        for (int k = 0; k < N; k++) sv[k] = SYM_W'(k);
        run(N, "full match");
        check("R7 full score no wrap", int'(max_score), N * MATCH);
        repeat (2) @(negedge clk);

        // All mismatch right after a high score: nothing may carry over
        for (int j = 0; j < N; j++) qv[j] = '0;
        for (int k = 0; k < 10; k++) sv[k] = 3'd1;
        run(10, "all mismatch");
        check("R10 fresh max score", int'(max_score), 0);
        check("R10 fresh max row", int'(max_row), 0);
        check("R10 fresh max col", int'(max_col), 0);
        repeat (2) @(negedge clk);

        // Single row with ties across every column
        for (int j = 0; j < N; j++) qv[j] = 3'd2;
        sv[0] = 3'd2;
        run(1, "single row tie");
        check("R6 tie goes to first column", int'(max_col), 1);
        repeat (2) @(negedge clk);

        // Long run on a small alphabet
        for (int j = 0; j < N; j++) qv[j] = SYM_W'($urandom % 4);
        for (int k = 0; k < 60; k++) sv[k] = SYM_W'($urandom % 4);
        run(60, "long random");
        repeat (1) @(negedge clk);

        for (int r = 0; r < 8; r++) begin
            int m;
            m = 1 + int'($urandom % 40);
            for (int j = 0; j < N; j++) qv[j] = SYM_W'($urandom % 4);
            for (int k = 0; k < m; k++) sv[k] = SYM_W'($urandom % 4);
            run(m, "random");
            repeat (1 + int'($urandom % 3)) @(negedge clk);
        end

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 ready cleared by reset", int'(tb_ready), 0);
        check("R9 max cleared by reset", int'(max_score), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule